// File: doc/BRIEF.md
# Tower-Field Cuber for GF(3^6m)

This unit raises an element of the sextic extension GF(3^6m) to the third power in a single combinational pass. The extension is built in two steps. First a quadratic layer GF(3^2m) = GF(3^m)[y]/(y^2 + 1) is formed. A cubic layer GF(3^6m) = GF(3^2m)[z]/(z^3 - z - 1) is then built on top of it. Cubing is the Frobenius map in characteristic three, so it acts on each tower coefficient separately. The cube of ã0 + ã1·z + ã2·z^2 is therefore ã0^3 + ã1^3·z^3 + ã2^3·z^6. Each quadratic-layer cube (c0 + c1·y)^3 is c0^3 - c1^3·y.

Six base-field cubers do the work. Each one reduces modulo a trinomial x^M + PT·x^T + P0 that is set by parameters. The z^3 and z^6 terms are folded back with z^3 = z + 1 and z^6 = z^2 - z + 1. This folding costs three quadratic-layer additions or subtractions, and each of those is a row of GF(3) digit adders. Negation is done by swapping the two bits of a digit. The block has no state. In a pairing datapath it sits between registers, and it returns the cube within the same clock cycle.

Top module: `tower_cube6`

## Requirements
- R1: A GF(3) digit is two bits: 2'b00 = 0, 2'b01 = 1, 2'b10 = 2. When no input digit uses the code 2'b11, no output digit uses it either.
- R2: Port packing is the same for input and output. Base element (2k+h) sits at bits [(2k+h)·2M +: 2M], where k is the z-power 0..2 and h is 0 for the real half and 1 for the y half. Digit i of a base element sits at bits [2i +: 2] within it.
- R3: Each base-field cube is reduced modulo x^M + PT·x^T + P0. An element b placed in the real half of coefficient 0 gives b^3 in the same place and zero in every other place.
- R4: A value b in the y half of coefficient 0 gives -(b^3) in that y half. A quadratic-layer coefficient whose y half is zero gives a cube whose y half is zero.
- R5: For any input t, the output equals t·t·t computed in the tower with y^2 = -1 and z^3 = z + 1.
- R6: Zero maps to zero. The unit element maps to the unit element.
- R7: The input z gives 1 + z. The input z^2 gives 1 - z + z^2, which has digit code 2 in the real half of coefficient 1.
- R8: When the coefficients ã1 and ã2 are equal, output coefficient 1 is zero.
- R9: The output follows the input with no clock edge in between.
- R10: The map is additive: cube(a + b) = cube(a) + cube(b).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 12·M | Operand: three quadratic-layer coefficients, six base elements |
| c_o | output | 12·M | Cube of the operand, packed the same way |

## Verification
Several checks are evaluated every time the logic settles. No base cuber produces an illegal digit code. A zero or constant base input is fixed by the cuber. A real-only quadratic coefficient stays real. Equal z and z^2 coefficients cancel in output coefficient 1. Other properties need stimulus and an independent arithmetic model in the bench: the full tower result, the sign fold of z^6, the negated y half, additivity, and the exact trinomial reduction. The bench covers them with an exhaustive sweep of base values, every single-digit basis element, and random operands.

// File: rtl/gf3_pkg.sv
package gf3_pkg;
  // digit code: 00 = 0, 01 = 1, 10 = 2
  function automatic logic [1:0] gf3_add(input logic [1:0] a, input logic [1:0] b);
    logic t;
    t = (a[0] | b[1]) ^ (a[1] | b[0]);
    return {(a[0] | b[0]) ^ t, (a[1] | b[1]) ^ t};
  endfunction

  function automatic logic [1:0] gf3_neg(input logic [1:0] a);
    return {a[0], a[1]};
  endfunction

  function automatic logic [1:0] gf3_scale(input int k, input logic [1:0] a);
    if (k == 1) return a;
    if (k == 2) return gf3_neg(a);
    return 2'b00;
  endfunction
endpackage

// File: rtl/gf3m_add.sv
module gf3m_add #(
  parameter int M     = 97,
  parameter bit NEG_B = 1'b0
) (
  input  logic [2*M-1:0] a_i,
  input  logic [2*M-1:0] b_i,
  output logic [2*M-1:0] s_o
);
  import gf3_pkg::*;

  for (genvar i = 0; i < M; i++) begin : g_dig
    if (NEG_B) begin : g_sub
      assign s_o[2*i +: 2] = gf3_add(a_i[2*i +: 2], gf3_neg(b_i[2*i +: 2]));
    end else begin : g_add
      assign s_o[2*i +: 2] = gf3_add(a_i[2*i +: 2], b_i[2*i +: 2]);
    end
  end
endmodule

// File: rtl/gf3m_cube.sv
module gf3m_cube #(
  parameter int M  = 97,
  parameter int T  = 16,
  parameter int PT = 1,
  parameter int P0 = 2
) (
  input  logic [2*M-1:0] a_i,
  output logic [2*M-1:0] c_o
);
  import gf3_pkg::*;

  localparam int NLEN = 3*M - 2;
  localparam int KT   = (3 - PT) % 3;  // x^M = KT*x^T + K0
  localparam int K0   = (3 - P0) % 3;

  logic [1:0] acc [NLEN];

  // spread digits to x^(3i), then fold from the top down
  always_comb begin
    for (int j = 0; j < NLEN; j++) acc[j] = 2'b00;
    for (int i = 0; i < M; i++) acc[3*i] = a_i[2*i +: 2];
    for (int d = NLEN - 1; d >= M; d--) begin
      acc[d-M+T] = gf3_add(acc[d-M+T], gf3_scale(KT, acc[d]));
      acc[d-M]   = gf3_add(acc[d-M],   gf3_scale(K0, acc[d]));
    end
    for (int j = 0; j < M; j++) c_o[2*j +: 2] = acc[j];
  end

  logic in_legal, out_legal;
  always_comb begin
    in_legal  = 1'b1;
    out_legal = 1'b1;
    for (int i = 0; i < M; i++) begin
      if (a_i[2*i +: 2] == 2'b11) in_legal = 1'b0;
      if (c_o[2*i +: 2] == 2'b11) out_legal = 1'b0;
    end
    if (in_legal) p_digit_legal_r1: assert (out_legal);
    if (a_i == '0) p_zero_fixed_r6: assert (c_o == '0);
    if (a_i[2*M-1:2] == '0) p_const_fixed_r3: assert (c_o == a_i);
  end
endmodule

// File: rtl/gf32m_cube.sv
module gf32m_cube #(
  parameter int M  = 97,
  parameter int T  = 16,
  parameter int PT = 1,
  parameter int P0 = 2
) (
  input  logic [4*M-1:0] a_i,
  output logic [4*M-1:0] c_o
);
  import gf3_pkg::*;

  localparam int W = 2*M;

  logic [W-1:0] im_cube;

  gf3m_cube #(.M(M), .T(T), .PT(PT), .P0(P0)) u_re (
    .a_i(a_i[0 +: W]), .c_o(c_o[0 +: W])
  );
  gf3m_cube #(.M(M), .T(T), .PT(PT), .P0(P0)) u_im (
    .a_i(a_i[W +: W]), .c_o(im_cube)
  );

  // y^3 = -y
  for (genvar i = 0; i < M; i++) begin : g_neg
    assign c_o[W + 2*i +: 2] = gf3_neg(im_cube[2*i +: 2]);
  end

  always_comb begin
    if (a_i[W +: W] == '0) p_real_stays_real_r4: assert (c_o[W +: W] == '0);
  end
endmodule

// File: rtl/tower_cube6.sv
module tower_cube6 #(
  parameter int M  = 97,
  parameter int T  = 16,
  parameter int PT = 1,
  parameter int P0 = 2
) (
  input  logic [12*M-1:0] a_i,
  output logic [12*M-1:0] c_o
);
  localparam int W = 2*M;
  localparam int E = 2*W;

  logic [E-1:0] s   [3];
  logic [W-1:0] s01 [2];

  for (genvar k = 0; k < 3; k++) begin : g_cub
    gf32m_cube #(.M(M), .T(T), .PT(PT), .P0(P0)) u_cub (
      .a_i(a_i[k*E +: E]), .c_o(s[k])
    );
  end

  // z^3 = z + 1, z^6 = z^2 - z + 1
  for (genvar h = 0; h < 2; h++) begin : g_half
    gf3m_add #(.M(M), .NEG_B(1'b0)) u_s01 (
      .a_i(s[0][h*W +: W]), .b_i(s[1][h*W +: W]), .s_o(s01[h])
    );
    gf3m_add #(.M(M), .NEG_B(1'b0)) u_c0 (
      .a_i(s01[h]), .b_i(s[2][h*W +: W]), .s_o(c_o[h*W +: W])
    );
    gf3m_add #(.M(M), .NEG_B(1'b1)) u_c1 (
      .a_i(s[1][h*W +: W]), .b_i(s[2][h*W +: W]), .s_o(c_o[E + h*W +: W])
    );
  end
  assign c_o[2*E +: E] = s[2];

  always_comb begin
    if (a_i[E +: E] == a_i[2*E +: E]) p_equal_mid_r8: assert (c_o[E +: E] == '0);
    if (a_i == '0) p_zero_top_r6: assert (c_o == '0);
  end
endmodule

// File: tb/sim_tower_cube6.sv
`timescale 1ns/1ps
module sim_tower_cube6;
  localparam int M  = 5;
  localparam int T  = 1;
  localparam int PT = 2;
  localparam int P0 = 1;
  localparam int W  = 2*M;
  localparam int N  = 6*W;

  typedef logic [W-1:0]   be_t;
  typedef logic [2*W-1:0] e2_t;
  typedef logic [N-1:0]   e6_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  e6_t  a = '0;
  e6_t  c;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  tower_cube6 #(.M(M), .T(T), .PT(PT), .P0(P0)) u0 (.a_i(a), .c_o(c));

  function automatic int dg(input logic [1:0] x);
    return (x == 2'b01) ? 1 : (x == 2'b10) ? 2 : 0;
  endfunction
  function automatic logic [1:0] en(input int v);
    int r;
    r = ((v % 3) + 3) % 3;
    return (r == 1) ? 2'b01 : (r == 2) ? 2'b10 : 2'b00;
  endfunction

  function automatic be_t bm_mul(input be_t x, input be_t y);
    int pr [2*M-1];
    be_t r;
    for (int i = 0; i < 2*M-1; i++) pr[i] = 0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++) pr[i+j] += dg(x[2*i +: 2]) * dg(y[2*j +: 2]);
    for (int d = 2*M-2; d >= M; d--) begin
      int cv;
      cv = ((pr[d] % 3) + 3) % 3;
      pr[d-M+T] -= PT*cv;
      pr[d-M]   -= P0*cv;
    end
    for (int j = 0; j < M; j++) r[2*j +: 2] = en(pr[j]);
    return r;
  endfunction
  function automatic e6_t addn(input e6_t x, input e6_t y, input bit neg);
    e6_t r;
    r = '0;
    for (int i = 0; i < N/2; i++)
      r[2*i +: 2] = en(dg(x[2*i +: 2]) + (neg ? 2 : 1) * dg(y[2*i +: 2]));
    return r;
  endfunction
  function automatic be_t ba(input be_t x, input be_t y, input bit neg);
    e6_t r;
    r = addn(e6_t'(x), e6_t'(y), neg);
    return r[W-1:0];
  endfunction
  function automatic e2_t ea(input e2_t x, input e2_t y, input bit neg);
    e6_t r;
    r = addn(e6_t'(x), e6_t'(y), neg);
    return r[2*W-1:0];
  endfunction
  function automatic e2_t e2_mul(input e2_t x, input e2_t y);
    be_t re, im;
    re = ba(bm_mul(x[0 +: W], y[0 +: W]), bm_mul(x[W +: W], y[W +: W]), 1'b1);
    im = ba(bm_mul(x[0 +: W], y[W +: W]), bm_mul(x[W +: W], y[0 +: W]), 1'b0);
    return {im, re};
  endfunction
  function automatic e6_t e6_mul(input e6_t x, input e6_t y);
    e2_t d [5];
    e2_t xc [3];
    e2_t yc [3];
    for (int k = 0; k < 3; k++) begin
      xc[k] = x[k*2*W +: 2*W];
      yc[k] = y[k*2*W +: 2*W];
    end
    for (int k = 0; k < 5; k++) d[k] = '0;
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) d[i+j] = ea(d[i+j], e2_mul(xc[i], yc[j]), 1'b0);
    return {ea(d[2], d[4], 1'b0), ea(ea(d[1], d[3], 1'b0), d[4], 1'b0), ea(d[0], d[3], 1'b0)};
  endfunction
  function automatic e6_t cube_ref(input e6_t x);
    return e6_mul(e6_mul(x, x), x);
  endfunction
  function automatic e6_t rnd_elem();
    e6_t r;
    for (int i = 0; i < N/2; i++) r[2*i +: 2] = en(int'($urandom_range(0, 2)));
    return r;
  endfunction

  task automatic chk(input string req, input e6_t exp);
    n_chk++;
    if (c !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, c, exp);
    end
  endtask
  task automatic drive(input e6_t x);
    @(posedge clk);
    #1 a = x;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    e6_t x, y, ex, ca, cb;
    be_t b;
    repeat (3) @(negedge clk);
    chk("R6 reset zero", '0);
    rst_ni = 1'b1;

    // R6 unit element
    x = '0; x[1:0] = 2'b01;
    drive(x); chk("R6 one", x);
    // R7 z -> 1 + z
    x = '0; x[2*W +: 2] = 2'b01;
    ex = '0; ex[1:0] = 2'b01; ex[2*W +: 2] = 2'b01;
    drive(x); chk("R7 z", ex);
    // R7 z^2 -> 1 - z + z^2
    x = '0; x[4*W +: 2] = 2'b01;
    ex = '0; ex[1:0] = 2'b01; ex[2*W +: 2] = 2'b10; ex[4*W +: 2] = 2'b01;
    drive(x); chk("R7 z^2", ex);
    // R4 y -> -y
    x = '0; x[W +: 2] = 2'b01;
    ex = '0; ex[W +: 2] = 2'b10;
    drive(x); chk("R4 y", ex);

    // R3 and R4: exhaustive base sweep in both halves of coefficient 0
    for (int v = 0; v < 3**M; v++) begin
      int r;
      r = v;
      for (int i = 0; i < M; i++) begin
        b[2*i +: 2] = en(r % 3);
        r = r / 3;
      end
      ex = '0; ex[0 +: W] = bm_mul(bm_mul(b, b), b);
      drive(e6_t'(b)); chk("R3 base cube", ex);
      x = '0; x[W +: W] = b;
      ex = '0; ex[W +: W] = ba('0, bm_mul(bm_mul(b, b), b), 1'b1);
      drive(x); chk("R4 y half", ex);
    end

    // R2 and R5: every single-digit basis element
    for (int p = 0; p < N/2; p++) begin
      for (int v = 1; v < 3; v++) begin
        x = '0; x[2*p +: 2] = en(v);
        drive(x); chk("R2 R5 basis", cube_ref(x));
      end
    end

    // R5 and R1: random operands
    for (int n = 0; n < 1500; n++) begin
      x = rnd_elem();
      drive(x); chk("R5 random", cube_ref(x));
      ex = c;
      for (int i = 0; i < N/2; i++) if (ex[2*i +: 2] == 2'b11) ex[2*i +: 2] = 2'b00;
      chk("R1 legal codes", ex);
    end

    // R8: equal z and z^2 coefficients
    for (int n = 0; n < 100; n++) begin
      x = rnd_elem(); x[4*W +: 2*W] = x[2*W +: 2*W];
      drive(x);
      ex = cube_ref(x);
      chk("R8 model", ex);
      n_chk++;
      if (c[2*W +: 2*W] !== '0) begin
        n_fail++;
        $display("FAIL R8 coef1: got %h expected 0", c[2*W +: 2*W]);
      end
    end

    // R10: additivity
    for (int n = 0; n < 200; n++) begin
      x = rnd_elem(); y = rnd_elem();
      drive(x); ca = c;
      drive(y); cb = c;
      drive(addn(x, y, 1'b0)); chk("R10 additive", addn(ca, cb, 1'b0));
    end

    // R9: output settles between edges
    for (int n = 0; n < 20; n++) begin
      x = rnd_elem();
      @(negedge clk);
      a = x;
      #1 chk("R9 no clock", cube_ref(x));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule